// File: doc/BRIEF.md
# Capability Dword Window

This block lets software reach a wide memory-mapped controller register set through an 8-byte capability in configuration space. The capability holds two writable fields: an 8-bit selector that picks one dword of the register set, and a 32-bit data field that mirrors that dword. Reading the data field returns the mirrored dword. Writing it pushes the whole dword back to the register set at byte address `selector * 4`.

The mirror is refreshed after every accepted write that lands anywhere in the capability, so the next configuration read sees the register set's own view of the dword. That view includes bits the register set keeps read-only or clears on write. The register set is sized for `N_SLOTS` hot-plug slots at `SET_HDR + 4*N_SLOTS` bytes. A selector that points at or past that size makes no register-set access, and the mirror reads zero. Two status flags from the command engine are shown, read-only, in the fourth capability byte.

A write sequence takes three cycles: accept, forward, reload. Configuration writes that arrive while a sequence is still running are dropped.

Top module: `cap_dword_window`

## Requirements
- R1: After reset the selector and data fields are 0, `cfg_rdata` is 0, and no register-set access is made until a capability write is accepted.
- R2: A read is registered and appears on `cfg_rdata` one cycle after `cfg_rd`. Capability dword 0 (`cfg_addr == CAP_OFS/4`) returns the selector in bits 23:16, `cmd_busy` in bit 26 and `cmd_pend` in bit 27, with all other bits 0. Capability dword 1 returns the data mirror. Any other address returns 0.
- R3: On capability dword 0, only byte lane 2 is writable, and it loads the selector. Lanes 0, 1 and 3 change nothing. On dword 1, each enabled lane loads the matching data byte.
- R4: An accepted write with any byte enable set on dword 1 produces, in the next cycle, exactly one `rs_wr` that carries the full 32-bit data field (merged bytes included) at `rs_addr = selector*4`.
- R5: Every accepted capability write is followed by one `rs_rd` at `selector*4`. The read comes in the cycle after the forward when there is one, and otherwise in the cycle after acceptance. The data field takes the `rs_rdata` value of that cycle.
- R6: When `selector*4 >= SET_HDR + 4*N_SLOTS`, neither `rs_wr` nor `rs_rd` is raised and the data field reloads as 0. Selector values just below the limit still reach the register set.
- R7: A configuration write that arrives while a forward or reload is pending is dropped: the selector and data fields keep their values and no extra access is made.
- R8: A write with all byte enables clear, or to an address outside the two capability dwords, makes no register-set access and leaves both fields unchanged.
- R9: `rs_wr` and `rs_rd` are never high together, and an active `rs_addr` is dword aligned and inside the register set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | CFG_AW | Configuration dword address |
| cfg_be | input | 4 | Configuration byte enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Registered configuration read data |
| cmd_busy | input | 1 | Command engine busy flag, shown in bit 26 of dword 0 |
| cmd_pend | input | 1 | Command status pending flag, shown in bit 27 of dword 0 |
| rs_wr | output | 1 | Register-set dword write strobe |
| rs_rd | output | 1 | Register-set dword read strobe |
| rs_addr | output | RS_AW | Register-set byte address |
| rs_wdata | output | 32 | Register-set write data |
| rs_rdata | input | 32 | Register-set read data, valid in the same cycle as `rs_rd` |

## Verification
The assertions assume that the register set answers a read combinationally, so `rs_rdata` already holds the addressed dword in the cycle `rs_rd` is high. They also assume that a read issued right after a forwarded write sees that write. The bench models the register set in exactly that way, as a dword array that updates on the clock edge and answers reads combinationally. Its top byte is read-only, so a reload visibly differs from the value written.

Apart from one deliberate back-to-back pair that exercises the drop rule, stimulus leaves at least three idle cycles after each write. This lets the forward and reload finish before the next access.

// File: rtl/cdw_pkg.sv
package cdw_pkg;

  localparam int SEL_W  = 8;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_FWD  = 2'd1,
    SEQ_LOAD = 2'd2
  } seq_state_e;

  // Smallest power of two not below v (bounded loop, elaboration only).
  function automatic int pow2_ceil(input int v);
    int p;
    p = 1;
    for (int i = 0; i < 31; i++) begin
      if (p < v) p = p * 2;
    end
    return p;
  endfunction

  // Byte address of the dword chosen by a selector value.
  function automatic logic [SEL_W+1:0] sel_byte_addr(input logic [SEL_W-1:0] sel);
    return {sel, 2'b00};
  endfunction

  // True when the chosen dword lies inside a register set of set_bytes bytes.
  function automatic logic sel_in_set(input logic [SEL_W-1:0] sel, input int set_bytes);
    return int'(sel_byte_addr(sel)) < set_bytes;
  endfunction

  // Replace the enabled byte lanes of old_w with those of new_w.
  function automatic logic [WORD_W-1:0] lane_merge(input logic [WORD_W-1:0] old_w,
                                                   input logic [WORD_W-1:0] new_w,
                                                   input logic [LANES-1:0]  be);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < LANES; i++) begin
      r[i*8 +: 8] = be[i] ? new_w[i*8 +: 8] : old_w[i*8 +: 8];
    end
    return r;
  endfunction

  // Layout of capability dword 0 as seen by configuration reads.
  function automatic logic [WORD_W-1:0] head_word(input logic [SEL_W-1:0] sel,
                                                  input logic busy,
                                                  input logic pend);
    logic [7:0] flags;
    flags = {4'b0000, pend, busy, 2'b00};
    return {flags, sel, 16'h0000};
  endfunction

endpackage

// File: rtl/cdw_seq.sv
module cdw_seq
  import cdw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic hit_data,
  output logic st_fwd,
  output logic st_load,
  output logic idle
);

  seq_state_e state_q;
  seq_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (accept) state_d = hit_data ? SEQ_FWD : SEQ_LOAD;
      end
      SEQ_FWD:  state_d = SEQ_LOAD;
      SEQ_LOAD: state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  assign st_fwd  = (state_q == SEQ_FWD);
  assign st_load = (state_q == SEQ_LOAD);
  assign idle    = (state_q == SEQ_IDLE);

endmodule

// File: rtl/cdw_cap_regs.sv
module cdw_cap_regs
  import cdw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_we,
  input  logic [SEL_W-1:0]  sel_d,
  input  logic [LANES-1:0]  data_be,
  input  logic [WORD_W-1:0] data_d,
  input  logic              load_en,
  input  logic [WORD_W-1:0] load_d,
  output logic [SEL_W-1:0]  sel_q,
  output logic [WORD_W-1:0] data_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_we) sel_q <= sel_d;
  end

  // One flop group per byte lane; a reload overrides any lane write.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)          data_q[g*8 +: 8] <= 8'h00;
      else if (load_en)    data_q[g*8 +: 8] <= load_d[g*8 +: 8];
      else if (data_be[g]) data_q[g*8 +: 8] <= data_d[g*8 +: 8];
    end
  end

endmodule

// File: rtl/cdw_rs_port.sv
module cdw_rs_port
  import cdw_pkg::*;
#(
  parameter int SET_BYTES = 160,
  parameter int RS_AW     = 8
)(
  input  logic [SEL_W-1:0]  sel_q,
  input  logic [WORD_W-1:0] data_q,
  input  logic              do_fwd,
  input  logic              do_load,
  input  logic [WORD_W-1:0] rs_rdata,
  output logic              rs_wr,
  output logic              rs_rd,
  output logic [RS_AW-1:0]  rs_addr,
  output logic [WORD_W-1:0] rs_wdata,
  output logic [WORD_W-1:0] load_word,
  output logic              in_range
);

  localparam int BA_W = SEL_W + 2;

  logic [BA_W-1:0] byte_addr;

  assign byte_addr = sel_byte_addr(sel_q);
  assign in_range  = sel_in_set(sel_q, SET_BYTES);

  generate
    if (RS_AW >= BA_W) begin : g_wide
      assign rs_addr = in_range ? RS_AW'(byte_addr) : '0;
    end else begin : g_narrow
      assign rs_addr = in_range ? byte_addr[RS_AW-1:0] : '0;
    end
  endgenerate

  assign rs_wr     = do_fwd  & in_range;
  assign rs_rd     = do_load & in_range;
  assign rs_wdata  = data_q;
  assign load_word = in_range ? rs_rdata : '0;

endmodule

// File: rtl/cdw_read_port.sv
module cdw_read_port
  import cdw_pkg::*;
#(
  parameter int CFG_AW  = 10,
  parameter int CAP_DW0 = 50
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_rd,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [SEL_W-1:0]  sel_q,
  input  logic [WORD_W-1:0] data_q,
  input  logic              cmd_busy,
  input  logic              cmd_pend,
  output logic [WORD_W-1:0] cfg_rdata
);

  localparam logic [CFG_AW-1:0] A_HEAD = CFG_AW'(CAP_DW0);
  localparam logic [CFG_AW-1:0] A_DATA = CFG_AW'(CAP_DW0 + 1);

  logic [WORD_W-1:0] mux_word;

  always_comb begin
    mux_word = '0;
    if (cfg_addr == A_HEAD)      mux_word = head_word(sel_q, cmd_busy, cmd_pend);
    else if (cfg_addr == A_DATA) mux_word = data_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_rdata <= '0;
    else if (cfg_rd) cfg_rdata <= mux_word;
    else             cfg_rdata <= '0;
  end

endmodule

// File: rtl/cap_dword_window.sv
module cap_dword_window
  import cdw_pkg::*;
#(
  parameter int N_SLOTS   = 31,
  parameter int MAX_SLOTS = 31,
  parameter int SET_HDR   = 36,
  parameter int CFG_AW    = 10,
  parameter int CAP_OFS   = 200,
  localparam int SET_BYTES = SET_HDR + 4 * N_SLOTS,
  localparam int APERTURE  = pow2_ceil(SET_HDR + 4 * MAX_SLOTS),
  localparam int RS_AW     = $clog2(APERTURE)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              cmd_busy,
  input  logic              cmd_pend,
  output logic              rs_wr,
  output logic              rs_rd,
  output logic [RS_AW-1:0]  rs_addr,
  output logic [31:0]       rs_wdata,
  input  logic [31:0]       rs_rdata
);

  localparam int CAP_DW0 = CAP_OFS / 4;
  localparam logic [CFG_AW-1:0] A_HEAD = CFG_AW'(CAP_DW0);
  localparam logic [CFG_AW-1:0] A_DATA = CFG_AW'(CAP_DW0 + 1);

  // Named internal events, observed by the bound checker.
  logic              seq_idle;
  logic              st_fwd;
  logic              st_load;
  logic              hit_head;
  logic              hit_data;
  logic              accept;
  logic              in_range;
  logic [SEL_W-1:0]  sel_q;
  logic [WORD_W-1:0] data_q;
  logic [WORD_W-1:0] load_word;

  assign hit_head = (cfg_addr == A_HEAD) && (cfg_be != 4'h0);
  assign hit_data = (cfg_addr == A_DATA) && (cfg_be != 4'h0);
  assign accept   = cfg_wr && seq_idle && (hit_head || hit_data);

  cdw_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .hit_data (hit_data),
    .st_fwd   (st_fwd),
    .st_load  (st_load),
    .idle     (seq_idle)
  );

  cdw_cap_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_we  (accept && hit_head && cfg_be[2]),
    .sel_d   (cfg_wdata[23:16]),
    .data_be ((accept && hit_data) ? cfg_be : 4'h0),
    .data_d  (cfg_wdata),
    .load_en (st_load),
    .load_d  (load_word),
    .sel_q   (sel_q),
    .data_q  (data_q)
  );

  cdw_rs_port #(
    .SET_BYTES (SET_BYTES),
    .RS_AW     (RS_AW)
  ) u_rs (
    .sel_q     (sel_q),
    .data_q    (data_q),
    .do_fwd    (st_fwd),
    .do_load   (st_load),
    .rs_rdata  (rs_rdata),
    .rs_wr     (rs_wr),
    .rs_rd     (rs_rd),
    .rs_addr   (rs_addr),
    .rs_wdata  (rs_wdata),
    .load_word (load_word),
    .in_range  (in_range)
  );

  cdw_read_port #(
    .CFG_AW  (CFG_AW),
    .CAP_DW0 (CAP_DW0)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_rd    (cfg_rd),
    .cfg_addr  (cfg_addr),
    .sel_q     (sel_q),
    .data_q    (data_q),
    .cmd_busy  (cmd_busy),
    .cmd_pend  (cmd_pend),
    .cfg_rdata (cfg_rdata)
  );

endmodule

// File: rtl/cap_dword_window_chk.sv
module cap_dword_window_chk #(
  parameter int SET_BYTES = 160,
  parameter int RS_AW     = 8,
  parameter int CFG_AW    = 10,
  parameter int CAP_DW0   = 50
)(
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [3:0]        cfg_be,
  input logic              rs_wr,
  input logic              rs_rd,
  input logic [RS_AW-1:0]  rs_addr,
  input logic [31:0]       rs_rdata,
  input logic              seq_idle,
  input logic [7:0]        sel_q,
  input logic [31:0]       data_q
);

  logic sel_ok;
  assign sel_ok = (int'({sel_q, 2'b00}) < SET_BYTES);

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rs_wr && rs_rd));

  a_r9_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_wr || rs_rd) |-> ((int'(rs_addr) < SET_BYTES) && (rs_addr[1:0] == 2'b00)));

  // R4 and R5: a forward is always followed by the reload of the same dword.
  a_r4_fwd_then_reload: assert property (@(posedge clk) disable iff (!rst_n)
    rs_wr |=> (rs_rd && $stable(rs_addr)));

  a_r4_data_write_forwards: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && seq_idle && sel_ok && cfg_be != 4'h0 &&
     cfg_addr == CFG_AW'(CAP_DW0 + 1)) |=> rs_wr);

  a_r5_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    rs_rd |=> (data_q == $past(rs_rdata)));

  a_r7_drop_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !seq_idle) |=> $stable(sel_q));

endmodule

bind cap_dword_window cap_dword_window_chk #(
  .SET_BYTES (SET_BYTES),
  .RS_AW     (RS_AW),
  .CFG_AW    (CFG_AW),
  .CAP_DW0   (CAP_DW0)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_wr   (cfg_wr),
  .cfg_addr (cfg_addr),
  .cfg_be   (cfg_be),
  .rs_wr    (rs_wr),
  .rs_rd    (rs_rd),
  .rs_addr  (rs_addr),
  .rs_rdata (rs_rdata),
  .seq_idle (seq_idle),
  .sel_q    (sel_q),
  .data_q   (data_q)
);

// File: tb/cap_dword_window_tb.sv
module cap_dword_window_tb;

  localparam int SET_BYTES = 36 + 4 * 31;
  localparam int SET_DW    = SET_BYTES / 4;
  localparam int HEAD_A    = 200 / 4;
  localparam int DATA_A    = HEAD_A + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_rd = 1'b0;
  logic [9:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cmd_busy = 1'b0;
  logic        cmd_pend = 1'b0;
  logic        rs_wr;
  logic        rs_rd;
  logic [7:0]  rs_addr;
  logic [31:0] rs_wdata;
  logic [31:0] rs_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cap_dword_window u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cmd_busy(cmd_busy), .cmd_pend(cmd_pend),
    .rs_wr(rs_wr), .rs_rd(rs_rd), .rs_addr(rs_addr), .rs_wdata(rs_wdata),
    .rs_rdata(rs_rdata)
  );

  // Register-set stand-in: dword array, top byte read-only, combinational read.
  logic [31:0] regs   [SET_DW];
  logic [31:0] shadow [SET_DW];

  function automatic logic [31:0] seed_word(input int i);
    return {8'hC0 + 8'(i), 8'(i), ~8'(i), 8'h5A};
  endfunction

  initial begin
    for (int i = 0; i < SET_DW; i++) begin
      regs[i]   = seed_word(i);
      shadow[i] = seed_word(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rs_wr && int'(rs_addr) < SET_BYTES) regs[rs_addr / 4][23:0] <= rs_wdata[23:0];
  end
  assign rs_rdata = (int'(rs_addr) < SET_BYTES) ? regs[rs_addr / 4] : 32'h0;

  // Reference model state and expected register-set traffic per cycle.
  int          m_sel = 0;
  logic [31:0] m_data = '0;
  int          q_op[$];
  int          q_ad[$];
  logic [31:0] q_wd[$];

  function automatic void push_exp(input int op, input int ad, input logic [31:0] wd);
    q_op.push_back(op); q_ad.push_back(ad); q_wd.push_back(wd);
  endfunction

  function automatic void model_write(input int a, input logic [3:0] be, input logic [31:0] d);
    bit inr;
    if (be == 4'h0 || (a != HEAD_A && a != DATA_A)) begin
      push_exp(0, 0, 0);
      return;
    end
    if (a == HEAD_A && be[2]) m_sel = int'(d[23:16]);
    if (a == DATA_A)
      for (int b = 0; b < 4; b++) if (be[b]) m_data[b*8 +: 8] = d[b*8 +: 8];
    inr = (m_sel * 4) < SET_BYTES;
    push_exp(0, 0, 0);
    if (a == DATA_A) begin
      push_exp(inr ? 1 : 0, m_sel * 4, m_data);
      if (inr) shadow[m_sel] = {shadow[m_sel][31:24], m_data[23:0]};
    end
    push_exp(inr ? 2 : 0, m_sel * 4, 0);
    m_data = inr ? shadow[m_sel] : 32'h0;
  endfunction

  // Per-cycle comparison of the register-set port against the model.
  always @(negedge clk) begin
    int op; int ad; logic [31:0] wd;
    if (rst_n && !done) begin
      op = 0; ad = 0; wd = '0;
      if (q_op.size() > 0) begin
        op = q_op.pop_front(); ad = q_ad.pop_front(); wd = q_wd.pop_front();
      end
      checks++;
      if (rs_wr !== (op == 1) || rs_rd !== (op == 2)) begin
        errors++;
        $display("FAIL R4/R5/R6/R9 port strobes wr=%0b rd=%0b expected op=%0d", rs_wr, rs_rd, op);
      end else if (op != 0 && int'(rs_addr) != ad) begin
        errors++;
        $display("FAIL R4/R5 rs_addr got %0d expected %0d", rs_addr, ad);
      end else if (op == 1 && rs_wdata !== wd) begin
        errors++;
        $display("FAIL R4 rs_wdata got %h expected %h", rs_wdata, wd);
      end
    end
  end

  task automatic cfg_write(input int a, input logic [3:0] be, input logic [31:0] d,
                           input bit taken, input bit settle);
    @(posedge clk); #2;
    cfg_wr = 1'b1; cfg_addr = 10'(a); cfg_be = be; cfg_wdata = d;
    if (taken) model_write(a, be, d);
    @(posedge clk); #2;
    cfg_wr = 1'b0; cfg_be = 4'h0;
    if (settle) repeat (3) @(posedge clk);
  endtask

  task automatic cfg_read(input int a, input logic [31:0] exp, input string tag);
    @(posedge clk); #2;
    cfg_rd = 1'b1; cfg_addr = 10'(a);
    @(posedge clk); #2;
    cfg_rd = 1'b0;
    @(negedge clk);
    checks++;
    if (cfg_rdata !== exp) begin
      errors++;
      $display("FAIL %s read addr %0d got %h expected %h", tag, a, cfg_rdata, exp);
    end
  endtask

  function automatic logic [31:0] head_exp();
    return (32'(cmd_pend) << 27) | (32'(cmd_busy) << 26) | (32'(m_sel) << 16);
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (cfg_rdata !== 32'h0) begin
      errors++;
      $display("FAIL R1 cfg_rdata after reset got %h expected 0", cfg_rdata);
    end
    // R1: fields reset to zero
    cfg_read(HEAD_A, 32'h0, "R1");
    cfg_read(DATA_A, 32'h0, "R1");
    // R2: flag positions and unowned addresses
    cmd_busy = 1'b1;
    cfg_read(HEAD_A, head_exp(), "R2");
    cmd_busy = 1'b0; cmd_pend = 1'b1;
    cfg_read(HEAD_A, head_exp(), "R2");
    cmd_pend = 1'b0;
    cfg_read(HEAD_A - 1, 32'h0, "R2");
    // R3/R5: select write then reload
    cfg_write(HEAD_A, 4'b0100, 32'h0005_0000, 1'b1, 1'b1);
    cfg_read(HEAD_A, head_exp(), "R3");
    cfg_read(DATA_A, m_data, "R5");
    // R4: full data write forwarded, reload shows read-only top byte
    cfg_write(DATA_A, 4'hF, 32'h1234_5678, 1'b1, 1'b1);
    cfg_read(DATA_A, m_data, "R4");
    // R3/R4: partial lane write forwards the merged dword
    cfg_write(DATA_A, 4'b0001, 32'hFFFF_FF99, 1'b1, 1'b1);
    cfg_read(DATA_A, m_data, "R3");
    // R3: read-only lanes of dword 0 do not move the selector
    cfg_write(HEAD_A, 4'b1011, 32'hFF33_FFFF, 1'b1, 1'b1);
    cfg_read(HEAD_A, head_exp(), "R3");
    // R8: empty enables and foreign addresses
    cfg_write(DATA_A, 4'h0, 32'hDEAD_BEEF, 1'b1, 1'b1);
    cfg_write(HEAD_A + 2, 4'hF, 32'hDEAD_BEEF, 1'b1, 1'b1);
    cfg_read(DATA_A, m_data, "R8");
    cfg_read(HEAD_A, head_exp(), "R8");
    // R6: last in-range dword
    cfg_write(HEAD_A, 4'b0100, 32'h0027_0000, 1'b1, 1'b1);
    cfg_write(DATA_A, 4'hF, 32'h00AB_CDEF, 1'b1, 1'b1);
    cfg_read(DATA_A, m_data, "R6");
    // R6: first out-of-range dword and the top selector value
    cfg_write(HEAD_A, 4'b0100, 32'h0028_0000, 1'b1, 1'b1);
    cfg_read(DATA_A, 32'h0, "R6");
    cfg_write(DATA_A, 4'hF, 32'h5555_AAAA, 1'b1, 1'b1);
    cfg_read(DATA_A, 32'h0, "R6");
    cfg_write(HEAD_A, 4'b0100, 32'h00FF_0000, 1'b1, 1'b1);
    cfg_read(HEAD_A, head_exp(), "R6");
    cfg_read(DATA_A, 32'h0, "R6");
    // R7: write arriving during a pending sequence is dropped
    cfg_write(HEAD_A, 4'b0100, 32'h0007_0000, 1'b1, 1'b1);
    cfg_write(DATA_A, 4'hF, 32'hAABB_CCDD, 1'b1, 1'b0);
    cfg_write(HEAD_A, 4'b0100, 32'h0009_0000, 1'b0, 1'b1);
    cfg_read(HEAD_A, head_exp(), "R7");
    cfg_read(DATA_A, m_data, "R7");
    // R4/R5: dword zero
    cfg_write(HEAD_A, 4'b0100, 32'h0000_0000, 1'b1, 1'b1);
    cfg_write(DATA_A, 4'b0110, 32'h0102_0304, 1'b1, 1'b1);
    cfg_read(DATA_A, m_data, "R4");
    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired before the run ended");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule